// File: doc/BRIEF.md
# Serial Add-Compare-Select Engine for a 256-State Rate-1/2 Trellis

This block performs the forward half of soft-decision maximum-likelihood decoding for a rate-1/2 convolutional code. The code has constraint length 9, which gives 256 encoder states, and its generators are 753 and 561 in octal. For every trellis stage the block takes one pair of signed 8-bit soft values. It then visits the 256 destination states one per clock. At each state it forms a correlation branch metric for both incoming branches, adds each to its predecessor's state metric, and keeps the larger sum. The index of the winning predecessor goes out as a single survivor decision bit. A downstream traceback unit collects these bits through a plain write interface.

One time-shared add-compare-select datapath does all the work, sequenced by a small control FSM. The FSM states are IDLE, INIT, FETCH, ACS and DONE. The transitions are:
- IDLE→INIT on `start`.
- INIT→FETCH after 256 initialisation writes.
- FETCH→ACS after one symbol-capture cycle.
- ACS→FETCH after the 256th destination when stages remain.
- ACS→DONE after the 256th destination of the final stage.
- DONE→IDLE unconditionally.

State metrics live in two register banks that swap roles at each stage. A block holds either 64 or 384 stages, chosen per block.

Top module: `vit_acs_engine`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy`, `done`, `sym_take` and `surv_we` are all 0.
- R2: A `start` seen in IDLE causes exactly 256 INIT cycles with `busy`=1 and no survivor write or symbol capture. These cycles set state 0's metric to 0 and every other state's metric to -8192.
- R3: Each stage begins with one FETCH cycle in which `sym_take`=1. `sd0`/`sd1` are captured at the end of that cycle, and `sym_take` is never high two cycles in a row.
- R4: In each stage's ACS phase, `surv_we` is 1 for 256 consecutive cycles, visiting destinations 0 to 255 in ascending order. `surv_addr` equals stage×256 + destination: the stage number sits in the upper bits and the destination in bits [7:0].
- R5: Destination d is reached from predecessors p0 = {d[6:0],0} and p1 = {d[6:0],1}, with input bit u = d[7].
  - For predecessor p, the branch word bits are c0 = parity({u,p} & 9'o753) and c1 = parity({u,p} & 9'o561).
  - The branch metric is (c0 ? −sd0 : +sd0) + (c1 ? −sd1 : +sd1), so a coded 0 maps to +1 and a coded 1 maps to −1.
- R6: The candidate with the larger sum wins. A tie goes to p0. `surv_bit` is the least significant bit of the winning predecessor.
- R7: `acs_metric` is the winning sum modulo 2^16. Candidates are compared by their 16-bit wrapped difference, so decisions remain correct after the metrics wrap in 384-stage blocks.
- R8: `blk_long`, sampled together with `start`, selects 384 stages when 1 and 64 stages when 0.
- R9: After the last stage's final destination, `done` is 1 for exactly one cycle, and `busy` returns to 0 in the next cycle.
- R10: While `busy`=1, a `start` pulse or a change of `blk_long` has no effect on the write sequence or on the block length.
- R11: Every destination of a stage uses only the metrics written by the previous stage (or by INIT), never metrics already updated in the current stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (honoured only in IDLE) |
| blk_long | input | 1 | Block length select: 1 = 384 stages, 0 = 64 stages |
| sd0 | input | 8 | Signed soft value paired with generator 753 |
| sd1 | input | 8 | Signed soft value paired with generator 561 |
| sym_take | output | 1 | High during the cycle in which sd0/sd1 are captured |
| busy | output | 1 | High from INIT through DONE |
| done | output | 1 | One-cycle pulse ending a block |
| surv_we | output | 1 | Survivor bit write strobe |
| surv_addr | output | 17 | Survivor address: {stage[8:0], destination[7:0]} |
| surv_bit | output | 1 | Survivor decision: 1 when predecessor {d[6:0],1} wins |
| acs_metric | output | 16 | Selected state metric for the current destination, wrapped to 16 bits |

## Verification
The bound checker watches, on every cycle, the protocol shape of the engine. This covers:
- survivor writes only while busy;
- single-cycle symbol captures and the single-cycle done pulse;
- destinations stepping by one within a stage;
- a start pulse never knocking the engine out of a run.

The numerical content cannot be seen by a local property: branch words, correlation signs, the tie rule, the wrapped comparison and the isolation between metric banks. The bench's integer reference model shows these by predicting every survivor bit and metric. It does so across clean encoded data, all-zero soft input that forces ties, and full-scale 384-stage input that drives the metrics through wrap-around.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

    localparam int unsigned CONSTRAINT_LEN = 9;
    localparam int unsigned STATE_BITS     = CONSTRAINT_LEN - 1;
    localparam int unsigned NUM_STATES     = 1 << STATE_BITS;

    localparam logic [STATE_BITS:0] GEN_A = 9'o753;
    localparam logic [STATE_BITS:0] GEN_B = 9'o561;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_FETCH,
        ST_ACS,
        ST_DONE
    } acs_state_e;

    // Bit 0 pairs with GEN_A, bit 1 with GEN_B; operand is {input bit, predecessor}.
    function automatic logic [1:0] branch_word(input logic [STATE_BITS:0] taps);
        return {^(taps & GEN_B), ^(taps & GEN_A)};
    endfunction

endpackage

// File: rtl/vit_acs_ctrl.sv
module vit_acs_ctrl
    import vit_acs_pkg::*;
#(
    parameter int unsigned SHORT_LEN = 64,
    parameter int unsigned LONG_LEN  = 384,
    parameter int unsigned STG_W     = $clog2(LONG_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  blk_long,
    output logic [STATE_BITS-1:0] cnt,
    output logic [STG_W-1:0]      stage,
    output logic                  bank,
    output logic                  busy,
    output logic                  sym_take,
    output logic                  init_we,
    output logic                  acs_we,
    output logic                  done
);

    localparam logic [STATE_BITS-1:0] LAST_ST    = '1;
    localparam logic [STG_W-1:0]      LAST_SHORT = STG_W'(SHORT_LEN - 1);
    localparam logic [STG_W-1:0]      LAST_LONG  = STG_W'(LONG_LEN - 1);

    acs_state_e state, nxt;
    logic       len_long;
    logic       last_stage;

    assign last_stage = (stage == (len_long ? LAST_LONG : LAST_SHORT));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_INIT;
            ST_INIT:  if (cnt == LAST_ST) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_ACS;
            ST_ACS:   if (cnt == LAST_ST) nxt = last_stage ? ST_DONE : ST_FETCH;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register together with its counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            stage    <= '0;
            bank     <= 1'b0;
            len_long <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_INIT || state == ST_ACS) cnt <= cnt + 1'b1;
            else                                      cnt <= '0;
            if (state == ST_IDLE) begin
                stage <= '0;
                bank  <= 1'b0;
                if (start) len_long <= blk_long;
            end else if (state == ST_ACS && cnt == LAST_ST) begin
                stage <= stage + 1'b1;
                bank  <= ~bank;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy     = 1'b1;
        sym_take = 1'b0;
        init_we  = 1'b0;
        acs_we   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:  busy     = 1'b0;
            ST_INIT:  init_we  = 1'b1;
            ST_FETCH: sym_take = 1'b1;
            ST_ACS:   acs_we   = 1'b1;
            ST_DONE:  done     = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/vit_acs_metric_ram.sv
module vit_acs_metric_ram
    import vit_acs_pkg::*;
#(
    parameter int unsigned METRIC_W = 16
) (
    input  logic                  clk,
    input  logic                  rd_bank,
    input  logic [STATE_BITS-1:0] rd_addr0,
    input  logic [STATE_BITS-1:0] rd_addr1,
    output logic [METRIC_W-1:0]   rd_data0,
    output logic [METRIC_W-1:0]   rd_data1,
    input  logic                  wr_en,
    input  logic                  wr_bank,
    input  logic [STATE_BITS-1:0] wr_addr,
    input  logic [METRIC_W-1:0]   wr_data
);

    logic [METRIC_W-1:0] mem_q [2][NUM_STATES];

    assign rd_data0 = mem_q[rd_bank][rd_addr0];
    assign rd_data1 = mem_q[rd_bank][rd_addr1];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_bank][wr_addr] <= wr_data;
    end

endmodule

// File: rtl/vit_acs_unit.sv
module vit_acs_unit
    import vit_acs_pkg::*;
#(
    parameter int unsigned SOFT_W   = 8,
    parameter int unsigned METRIC_W = 16
) (
    input  logic [STATE_BITS-1:0]     dest,
    input  logic signed [SOFT_W-1:0]  sd0,
    input  logic signed [SOFT_W-1:0]  sd1,
    input  logic [METRIC_W-1:0]       old_m0,
    input  logic [METRIC_W-1:0]       old_m1,
    output logic [STATE_BITS-1:0]     pred0,
    output logic [STATE_BITS-1:0]     pred1,
    output logic                      pick,
    output logic [METRIC_W-1:0]       new_m
);

    localparam int unsigned BM_W = SOFT_W + 2;

    logic signed [BM_W-1:0] x0, x1;
    logic [METRIC_W-1:0]    old_m [2];
    logic [METRIC_W-1:0]    cand  [2];
    logic [METRIC_W-1:0]    diff;

    assign x0       = BM_W'(sd0);
    assign x1       = BM_W'(sd1);
    assign old_m[0] = old_m0;
    assign old_m[1] = old_m1;
    assign pred0    = {dest[STATE_BITS-2:0], 1'b0};
    assign pred1    = {dest[STATE_BITS-2:0], 1'b1};

    for (genvar b = 0; b < 2; b++) begin : g_branch
        logic [STATE_BITS:0]    taps;
        logic [1:0]             bw;
        logic signed [BM_W-1:0] bm;
        assign taps = {dest[STATE_BITS-1], dest[STATE_BITS-2:0], 1'(b)};
        assign bw   = branch_word(taps);
        assign bm   = (bw[0] ? -x0 : x0) + (bw[1] ? -x1 : x1);
        assign cand[b] = old_m[b] + {{(METRIC_W-BM_W){bm[BM_W-1]}}, bm};
    end

    // Wrapped difference keeps the decision valid after metric overflow.
    assign diff  = cand[1] - cand[0];
    assign pick  = !diff[METRIC_W-1] && (diff != '0);
    assign new_m = pick ? cand[1] : cand[0];

endmodule

// File: rtl/vit_acs_engine.sv
module vit_acs_engine
    import vit_acs_pkg::*;
#(
    parameter int unsigned SOFT_W    = 8,
    parameter int unsigned METRIC_W  = 16,
    parameter int unsigned SHORT_LEN = 64,
    parameter int unsigned LONG_LEN  = 384,
    parameter int          INIT_NEG  = -8192,
    parameter int unsigned ADDR_W    = $clog2(LONG_LEN) + 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     blk_long,
    input  logic signed [SOFT_W-1:0] sd0,
    input  logic signed [SOFT_W-1:0] sd1,
    output logic                     sym_take,
    output logic                     busy,
    output logic                     done,
    output logic                     surv_we,
    output logic [ADDR_W-1:0]        surv_addr,
    output logic                     surv_bit,
    output logic [METRIC_W-1:0]      acs_metric
);

    localparam int unsigned STG_W = ADDR_W - STATE_BITS;

    logic [STATE_BITS-1:0]    cnt, pred0, pred1;
    logic [STG_W-1:0]         stage;
    logic                     bank, init_we, acs_we, pick;
    logic signed [SOFT_W-1:0] sd0_q, sd1_q;
    logic [METRIC_W-1:0]      m0, m1, new_m, wdata;

    vit_acs_ctrl #(
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .STG_W(STG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_long(blk_long),
        .cnt(cnt), .stage(stage), .bank(bank), .busy(busy),
        .sym_take(sym_take), .init_we(init_we), .acs_we(acs_we), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd0_q <= '0;
            sd1_q <= '0;
        end else if (sym_take) begin
            sd0_q <= sd0;
            sd1_q <= sd1;
        end
    end

    vit_acs_unit #(.SOFT_W(SOFT_W), .METRIC_W(METRIC_W)) u_acs (
        .dest(cnt), .sd0(sd0_q), .sd1(sd1_q), .old_m0(m0), .old_m1(m1),
        .pred0(pred0), .pred1(pred1), .pick(pick), .new_m(new_m)
    );

    assign wdata = init_we ? ((cnt == '0) ? '0 : METRIC_W'(INIT_NEG)) : new_m;

    vit_acs_metric_ram #(.METRIC_W(METRIC_W)) u_mem (
        .clk(clk), .rd_bank(bank), .rd_addr0(pred0), .rd_addr1(pred1),
        .rd_data0(m0), .rd_data1(m1),
        .wr_en(init_we | acs_we), .wr_bank(init_we ? 1'b0 : ~bank),
        .wr_addr(cnt), .wr_data(wdata)
    );

    assign surv_we    = acs_we;
    assign surv_addr  = {stage, cnt};
    assign surv_bit   = pick;
    assign acs_metric = new_m;

endmodule

// File: rtl/vit_acs_checker.sv
module vit_acs_checker #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              sym_take,
    input logic              busy,
    input logic              done,
    input logic              surv_we,
    input logic [ADDR_W-1:0] surv_addr
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!surv_we && !sym_take && !done));

    p_take_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_take |=> !sym_take);

    p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        surv_we |-> busy);

    p_dest_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (surv_we && surv_addr[7:0] != 8'hFF) |=>
            (surv_we && surv_addr == $past(surv_addr) + 1'b1));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind vit_acs_engine vit_acs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sym_take(sym_take),
    .busy(busy), .done(done), .surv_we(surv_we), .surv_addr(surv_addr)
);

// File: tb/vit_acs_engine_tb.sv
module vit_acs_engine_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              blk_long = 1'b0;
    logic signed [7:0] sd0 = '0;
    logic signed [7:0] sd1 = '0;
    logic              sym_take, busy, done, surv_we, surv_bit;
    logic [16:0]       surv_addr;
    logic [15:0]       acs_metric;

    int checks = 0;
    int errors = 0;
    int lcg    = 12345;
    int enc_reg = 0;
    int sm_old [256];
    int sm_new [256];

    always #10 clk = ~clk;

    vit_acs_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_long(blk_long),
        .sd0(sd0), .sd1(sd1), .sym_take(sym_take), .busy(busy), .done(done),
        .surv_we(surv_we), .surv_addr(surv_addr), .surv_bit(surv_bit),
        .acs_metric(acs_metric)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int parity9(input int v);
        int p = 0;
        for (int i = 0; i < 9; i++) p ^= (v >> i) & 1;
        return p;
    endfunction

    function automatic int rnd();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 16) & 32'h7fff;
    endfunction

    // mode 0: encoded random bits with noise; 1: all zero; 2: full-scale random
    task automatic make_symbol(input int mode, output int s0, output int s1);
        int u, c0, c1;
        if (mode == 1) begin
            s0 = 0; s1 = 0;
        end else if (mode == 2) begin
            s0 = (rnd() & 1) ? 127 : -128;
            s1 = (rnd() & 1) ? 127 : -128;
        end else begin
            u  = rnd() & 1;
            c0 = parity9((u << 8) | enc_reg & 9'o753);
            c1 = parity9((u << 8) | enc_reg & 9'o561);
            c0 = parity9(((u << 8) | enc_reg) & 9'o753);
            c1 = parity9(((u << 8) | enc_reg) & 9'o561);
            enc_reg = (u << 7) | (enc_reg >> 1);
            s0 = (c0 ? -90 : 90) + (rnd() % 61) - 30;
            s1 = (c1 ? -90 : 90) + (rnd() % 61) - 30;
        end
    endtask

    task automatic run_block(input bit long_blk, input int mode, input bit poke);
        int nstg, s0, s1;
        nstg = long_blk ? 384 : 64;
        enc_reg = 0;
        for (int i = 0; i < 256; i++) sm_old[i] = (i == 0) ? 0 : -8192;
        @(negedge clk);
        start = 1'b1; blk_long = long_blk;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 256; i++) begin
            chk(busy && !surv_we && !sym_take && !done, "R2 init phase", {surv_we, sym_take}, 0);
            @(negedge clk);
        end
        for (int st = 0; st < nstg; st++) begin
            make_symbol(mode, s0, s1);
            sd0 = 8'(s0); sd1 = 8'(s1);
            chk(sym_take && !surv_we, "R3 fetch cycle", sym_take, 1);
            @(negedge clk);
            sd0 = '0; sd1 = '0;
            for (int d = 0; d < 256; d++) begin
                int u, p0, p1, bm0, bm1, cand0, cand1, ebit, emet;
                u  = d >> 7;
                p0 = (d & 127) << 1;
                p1 = p0 | 1;
                bm0 = (parity9(((u << 8) | p0) & 9'o753) ? -s0 : s0)
                    + (parity9(((u << 8) | p0) & 9'o561) ? -s1 : s1);
                bm1 = (parity9(((u << 8) | p1) & 9'o753) ? -s0 : s0)
                    + (parity9(((u << 8) | p1) & 9'o561) ? -s1 : s1);
                cand0 = sm_old[p0] + bm0;
                cand1 = sm_old[p1] + bm1;
                ebit  = (cand1 > cand0) ? 1 : 0;
                sm_new[d] = ebit ? cand1 : cand0;
                emet  = sm_new[d] & 32'hffff;
                chk(surv_we === 1'b1, "R4 write strobe", surv_we, 1);
                chk(surv_addr == 17'(st * 256 + d), "R4/R8 survivor address", surv_addr, st * 256 + d);
                chk(surv_bit == ebit[0], "R5/R6/R11 survivor bit", surv_bit, ebit);
                chk(int'(acs_metric) == emet, "R7 selected metric", acs_metric, emet);
                if (poke && st == 2 && d == 10) begin start = 1'b1; blk_long = ~long_blk; end
                if (poke && st == 2 && d == 11) begin start = 1'b0; blk_long = long_blk; end
                @(negedge clk);
            end
            for (int i = 0; i < 256; i++) sm_old[i] = sm_new[i];
        end
        chk(done && busy && !surv_we, "R9 done pulse", done, 1);
        @(negedge clk);
        chk(!done && !busy, "R9/R10 back to idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sym_take && !surv_we, "R1 reset state", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sym_take && !surv_we, "R1 idle after reset", busy, 0);
        run_block(1'b0, 0, 1'b1);   // R10: start and length poke mid-block
        run_block(1'b0, 1, 1'b0);   // R6: ties from zero soft input
        run_block(1'b1, 2, 1'b0);   // R7/R8: 384 full-scale stages with wrap
        repeat (2) @(negedge clk);
        chk(!busy && !surv_we, "R1 quiet after runs", busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule